// File: doc/BRIEF.md
# Flash Table Access Controller

This block connects an 8-bit processor data path to a program flash array that is 16 bits wide. The processor sees three byte-wide pointer registers, which together form one byte address, and a single 8-bit table latch. A table read moves one flash byte into the latch. A table write puts the latch byte into a staging buffer and does not touch flash. The pointer can step up or down by one after each table access, and any byte address is legal.

A command port starts the long operations. It can program one 16-bit word or a whole staging block from the buffer, or it can erase a fixed-size flash block. A bulk-erase command is refused. During a long operation an internal timer keeps the fetch stall output high and drives the flash one word per cycle. The timer then ends the operation by itself, raises a one-cycle done pulse and refills the staging buffer with 0xFF. The flash array sits outside the block. It returns read data combinationally for the current word address. It ANDs programmed data into the stored word and sets erased words to 0xFFFF.

Top module: `flash_table_ctrl`

## Requirements
- R1: After reset the pointer reads 0, the latch reads 0, busy, fetch_stall, done and err are low, and every staging byte holds 0xFF.
- R2: A table read while idle loads the latch with byte `ptr[0]` of flash word `ptr[23:1]`: the low half when `ptr[0]`=0 and the high half when it is 1. The latch is visible one cycle later. Any address is accepted.
- R3: With `tbl_step` = 1 the pointer increments after an accepted table access. With 2 it decrements. With 0 or 3 it holds. Stepping wraps modulo 2^24.
- R4: `ptr_sel` 0, 1 and 2 write bits [7:0], [15:8] and [23:16] of the pointer. When a byte write and a step fall in the same cycle, the table access uses the old pointer. The written byte then replaces its field of the stepped value, and the other fields keep the stepped value.
- R5: A table write while idle stores the latch into staging byte `ptr[5:0]` and leaves flash unchanged.
- R6: Command 0 (word) programs flash word `ptr[23:1]` with staging bytes {`ptr[5:1]`,1} in the high half and {`ptr[5:1]`,0} in the low half.
- R7: Command 1 (block) programs the 32 words starting at byte address `ptr` with bits [5:0] cleared, taking staging bytes in index order.
- R8: Command 2 (erase) sets to 0xFFFF the 512 words starting at byte address `ptr` with bits [9:0] cleared. Words outside that range are not touched.
- R9: Command 3 (bulk erase) does not start an operation or drive flash. It raises err for exactly the next cycle.
- R10: An accepted command raises busy and fetch_stall for exactly PROG_TICKS cycles, starting in the cycle after the command. done is high for the single cycle after busy falls. While busy, table reads, table writes and new commands are ignored.
- R11: When a word or block program completes, every staging byte returns to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_we | input | 1 | Write one pointer byte |
| ptr_sel | input | 2 | Pointer byte select (0 low, 1 high, 2 upper) |
| ptr_wdata | input | 8 | Pointer byte value |
| ptr_q | output | 24 | Current byte pointer |
| lat_we | input | 1 | Write the table latch directly |
| lat_wdata | input | 8 | Latch write value |
| lat_q | output | 8 | Table latch |
| tbl_rd | input | 1 | Table read request |
| tbl_wr | input | 1 | Table write request |
| tbl_step | input | 2 | Post-access step: 0 hold, 1 up, 2 down, 3 hold |
| cmd_start | input | 1 | Start a long operation |
| cmd_op | input | 2 | 0 word program, 1 block program, 2 block erase, 3 bulk erase |
| fetch_stall | output | 1 | Blocks instruction fetch while an operation runs |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refused-command pulse |
| fl_addr | output | 23 | Flash word address |
| fl_rdata | input | 16 | Flash read word for fl_addr |
| fl_prog | output | 1 | Program (AND) fl_wdata into the word at fl_addr |
| fl_erase | output | 1 | Erase the word at fl_addr |
| fl_wdata | output | 16 | Program data |

## Verification
Two events can fall in the same cycle. An accepted table read with post-increment can coincide with a write to one pointer byte. Separately, table and command requests can arrive while the timer is still running. For the first case the bench uses a pointer of 0x0000FF, asks for a read with increment and writes the middle byte in the same cycle. It then expects the latch to hold the byte at 0x0000FF and the pointer to read 0x005500. For the second case a read with increment and a bulk-erase command arrive in the second busy cycle. The latch and pointer must be unchanged and err must stay low.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

   typedef enum logic [1:0] {
      OP_WORD  = 2'd0,
      OP_BLOCK = 2'd1,
      OP_ERASE = 2'd2,
      OP_BULK  = 2'd3
   } ftc_op_e;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_INC  = 2'd1,
      STEP_DEC  = 2'd2,
      STEP_RSV  = 2'd3
   } ftc_step_e;

endpackage

// File: rtl/ftc_ptr.sv
module ftc_ptr
   import ftc_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int NBYTES = ADDR_W / 8,
   parameter int SEL_W  = $clog2(NBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  ftc_step_e         step,
   input  logic              byte_we,
   input  logic [SEL_W-1:0]  byte_sel,
   input  logic [7:0]        byte_wdata,
   output logic [ADDR_W-1:0] q
);

   logic [ADDR_W-1:0] stepped;
   logic [ADDR_W-1:0] nxt;

   always_comb begin
      stepped = q;
      if (step_en) begin
         case (step)
            STEP_INC: stepped = q + ADDR_W'(1);
            STEP_DEC: stepped = q - ADDR_W'(1);
            default:  stepped = q;
         endcase
      end
   end

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      assign nxt[8*g +: 8] = (byte_we && byte_sel == SEL_W'(g)) ? byte_wdata
                                                                 : stepped[8*g +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   // R3: post-increment and post-decrement
   a_r3_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step == STEP_INC && !byte_we) |=> q == $past(q) + ADDR_W'(1));
   a_r3_post_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step == STEP_DEC && !byte_we) |=> q == $past(q) - ADDR_W'(1));
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !byte_we) |=> $stable(q));
   // R4: an explicit byte write wins over the step for its own field
   a_r4_byte_override: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_we && byte_sel == '0) |=> q[7:0] == $past(byte_wdata));

endmodule

// File: rtl/ftc_hold.sv
module ftc_hold #(
   parameter int BYTES  = 64,
   parameter int IDX_W  = $clog2(BYTES),
   parameter int WIDX_W = IDX_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [7:0]        wdata,
   input  logic              clr,
   input  logic [WIDX_W-1:0] ridx,
   output logic [15:0]       rword
);

   logic [7:0] hb [BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < BYTES; i++) hb[i] <= 8'hFF;
      end else if (clr) begin
         for (int i = 0; i < BYTES; i++) hb[i] <= 8'hFF;
      end else if (we) begin
         hb[widx] <= wdata;
      end
   end

   assign rword = {hb[{ridx, 1'b1}], hb[{ridx, 1'b0}]};

   // R11: staging refilled after a commit
   a_r11_clear_fills: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> rword == 16'hFFFF);
   // R5: a written byte is visible on the word it belongs to
   a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clr && widx == {ridx, 1'b0}) |=> (rword[7:0] == $past(wdata)) || (ridx != $past(ridx)));

endmodule

// File: rtl/ftc_seq.sv
module ftc_seq
   import ftc_pkg::*;
#(
   parameter int WA          = 23,
   parameter int HOLD_WORDS  = 32,
   parameter int ERASE_WORDS = 512,
   parameter int PROG_TICKS  = 600,
   parameter int HW_W        = $clog2(HOLD_WORDS),
   parameter int EW_W        = $clog2(ERASE_WORDS),
   parameter int TICK_W      = $clog2(PROG_TICKS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  ftc_op_e         op,
   input  logic [WA-1:0]   ptr_word,
   output logic            busy,
   output logic            done,
   output logic            issue_prog,
   output logic            issue_erase,
   output logic [WA-1:0]   addr,
   output logic [HW_W-1:0] hidx,
   output logic            commit_end
);

   localparam logic [TICK_W-1:0] N_WORD  = TICK_W'(1);
   localparam logic [TICK_W-1:0] N_BLOCK = TICK_W'(HOLD_WORDS);
   localparam logic [TICK_W-1:0] N_ERASE = TICK_W'(ERASE_WORDS);
   localparam logic [TICK_W-1:0] T_LAST  = TICK_W'(PROG_TICKS - 1);

   ftc_op_e           op_r;
   logic [WA-1:0]     base_r;
   logic [WA-1:0]     base_nxt;
   logic [HW_W-1:0]   widx_r;
   logic [TICK_W-1:0] tick;
   logic [TICK_W-1:0] nwords;
   logic              last;
   logic              active;

   always_comb begin
      case (op)
         OP_BLOCK: base_nxt = {ptr_word[WA-1:HW_W], {HW_W{1'b0}}};
         OP_ERASE: base_nxt = {ptr_word[WA-1:EW_W], {EW_W{1'b0}}};
         default:  base_nxt = ptr_word;
      endcase
   end

   always_comb begin
      case (op_r)
         OP_BLOCK: nwords = N_BLOCK;
         OP_ERASE: nwords = N_ERASE;
         default:  nwords = N_WORD;
      endcase
   end

   assign last = (tick == T_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         op_r   <= OP_WORD;
         base_r <= '0;
         widx_r <= '0;
         tick   <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy   <= 1'b1;
               tick   <= '0;
               op_r   <= op;
               base_r <= base_nxt;
               widx_r <= ptr_word[HW_W-1:0];
            end
         end else if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            tick <= tick + TICK_W'(1);
         end
      end
   end

   assign active      = busy && (tick < nwords);
   assign issue_prog  = active && (op_r != OP_ERASE);
   assign issue_erase = active && (op_r == OP_ERASE);
   assign addr        = base_r + WA'(tick);
   assign hidx        = (op_r == OP_WORD) ? widx_r : tick[HW_W-1:0];
   assign commit_end  = busy && last && (op_r != OP_ERASE);

   // R10: start, completion pulse and timer bound
   a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   a_r10_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (tick <= T_LAST));
   // R8: erase traffic stays inside the block chosen at start
   a_r8_erase_in_block: assert property (@(posedge clk) disable iff (!rst_n)
      issue_erase |-> (addr[WA-1:EW_W] == base_r[WA-1:EW_W]));

endmodule

// File: rtl/flash_table_ctrl.sv
module flash_table_ctrl
   import ftc_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int HOLD_BYTES  = 64,
   parameter int ERASE_BYTES = 1024,
   parameter int PROG_TICKS  = 600
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ptr_we,
   input  logic [$clog2(ADDR_W/8)-1:0]   ptr_sel,
   input  logic [7:0]                    ptr_wdata,
   output logic [ADDR_W-1:0]             ptr_q,
   input  logic                          lat_we,
   input  logic [7:0]                    lat_wdata,
   output logic [7:0]                    lat_q,
   input  logic                          tbl_rd,
   input  logic                          tbl_wr,
   input  logic [1:0]                    tbl_step,
   input  logic                          cmd_start,
   input  logic [1:0]                    cmd_op,
   output logic                          fetch_stall,
   output logic                          busy,
   output logic                          done,
   output logic                          err,
   output logic [ADDR_W-2:0]             fl_addr,
   input  logic [15:0]                   fl_rdata,
   output logic                          fl_prog,
   output logic                          fl_erase,
   output logic [15:0]                   fl_wdata
);

   localparam int NPB         = ADDR_W / 8;
   localparam int PSEL_W      = $clog2(NPB);
   localparam int WA          = ADDR_W - 1;
   localparam int HIDX_W      = $clog2(HOLD_BYTES);
   localparam int HOLD_WORDS  = HOLD_BYTES / 2;
   localparam int ERASE_WORDS = ERASE_BYTES / 2;

   if (ADDR_W % 8 != 0 || NPB < 2) begin : g_bad_addr
      $error("ADDR_W must be a multiple of 8 and at least 16");
   end
   if (HOLD_BYTES < 4 || (1 << HIDX_W) != HOLD_BYTES) begin : g_bad_hold
      $error("HOLD_BYTES must be a power of two, at least 4");
   end
   if (ERASE_BYTES < HOLD_BYTES || (1 << $clog2(ERASE_BYTES)) != ERASE_BYTES
       || ERASE_BYTES >= (1 << (ADDR_W - 1))) begin : g_bad_erase
      $error("ERASE_BYTES must be a power of two within the address space and not below HOLD_BYTES");
   end
   if (PROG_TICKS < ERASE_WORDS) begin : g_bad_ticks
      $error("PROG_TICKS must cover one cycle per erased word");
   end

   logic            tbl_go;
   logic            seq_busy;
   logic            seq_prog;
   logic            seq_erase;
   logic [WA-1:0]   seq_addr;
   logic [HIDX_W-2:0] seq_hidx;
   logic            commit_end;
   logic            bulk_req;
   logic            err_r;
   logic [15:0]     hold_word;

   assign tbl_go   = !seq_busy && (tbl_rd || tbl_wr);
   assign bulk_req = cmd_start && (ftc_op_e'(cmd_op) == OP_BULK);

   ftc_ptr #(
      .ADDR_W (ADDR_W),
      .NBYTES (NPB),
      .SEL_W  (PSEL_W)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_en    (tbl_go),
      .step       (ftc_step_e'(tbl_step)),
      .byte_we    (ptr_we),
      .byte_sel   (ptr_sel),
      .byte_wdata (ptr_wdata),
      .q          (ptr_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
      end else if (!seq_busy && tbl_rd) begin
         lat_q <= ptr_q[0] ? fl_rdata[15:8] : fl_rdata[7:0];
      end else if (lat_we) begin
         lat_q <= lat_wdata;
      end
   end

   ftc_hold #(
      .BYTES  (HOLD_BYTES),
      .IDX_W  (HIDX_W),
      .WIDX_W (HIDX_W - 1)
   ) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (!seq_busy && tbl_wr),
      .widx  (ptr_q[HIDX_W-1:0]),
      .wdata (lat_q),
      .clr   (commit_end),
      .ridx  (seq_hidx),
      .rword (hold_word)
   );

   ftc_seq #(
      .WA          (WA),
      .HOLD_WORDS  (HOLD_WORDS),
      .ERASE_WORDS (ERASE_WORDS),
      .PROG_TICKS  (PROG_TICKS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (cmd_start && !bulk_req),
      .op          (ftc_op_e'(cmd_op)),
      .ptr_word    (ptr_q[ADDR_W-1:1]),
      .busy        (seq_busy),
      .done        (done),
      .issue_prog  (seq_prog),
      .issue_erase (seq_erase),
      .addr        (seq_addr),
      .hidx        (seq_hidx),
      .commit_end  (commit_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_r <= 1'b0;
      else        err_r <= bulk_req && !seq_busy;
   end

   assign err         = err_r;
   assign busy        = seq_busy;
   assign fetch_stall = seq_busy;
   assign fl_addr     = seq_busy ? seq_addr : ptr_q[ADDR_W-1:1];
   assign fl_prog     = seq_prog;
   assign fl_erase    = seq_erase;
   assign fl_wdata    = hold_word;

   // R10: flash is only driven while fetch is stalled
   a_r10_stall_covers_flash: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_prog || fl_erase) |-> fetch_stall);
   // R10: reads are refused while busy
   a_r10_read_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && tbl_rd && !lat_we) |=> $stable(lat_q));
   // R9: bulk erase is refused with an error pulse
   a_r9_bulk_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (bulk_req && !seq_busy) |=> (err && !busy));
   // R5: a table write never reaches flash directly
   a_r5_no_direct_prog: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_wr && !seq_busy) |-> !fl_prog);

endmodule

// File: tb/flash_table_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_table_ctrl_tb_top;

   localparam int T = 600;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_we = 1'b0;
   logic [1:0]  ptr_sel = '0;
   logic [7:0]  ptr_wdata = '0;
   logic [23:0] ptr_q;
   logic        lat_we = 1'b0;
   logic [7:0]  lat_wdata = '0;
   logic [7:0]  lat_q;
   logic        tbl_rd = 1'b0;
   logic        tbl_wr = 1'b0;
   logic [1:0]  tbl_step = '0;
   logic        cmd_start = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic        fetch_stall, busy, done, err;
   logic [22:0] fl_addr;
   logic [15:0] fl_rdata;
   logic        fl_prog, fl_erase;
   logic [15:0] fl_wdata;

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0] mem   [2048];
   logic [15:0] model [2048];

   always #4 clk = ~clk;

   flash_table_ctrl #(.PROG_TICKS(T)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata), .ptr_q(ptr_q),
      .lat_we(lat_we), .lat_wdata(lat_wdata), .lat_q(lat_q),
      .tbl_rd(tbl_rd), .tbl_wr(tbl_wr), .tbl_step(tbl_step),
      .cmd_start(cmd_start), .cmd_op(cmd_op),
      .fetch_stall(fetch_stall), .busy(busy), .done(done), .err(err),
      .fl_addr(fl_addr), .fl_rdata(fl_rdata), .fl_prog(fl_prog),
      .fl_erase(fl_erase), .fl_wdata(fl_wdata)
   );

   // behavioural flash: programming ANDs, erase sets all ones
   assign fl_rdata = mem[fl_addr[10:0]];
   always @(posedge clk) begin
      if (fl_prog)  mem[fl_addr[10:0]] <= mem[fl_addr[10:0]] & fl_wdata;
      if (fl_erase) mem[fl_addr[10:0]] <= 16'hFFFF;
   end

   initial begin
      for (int i = 0; i < 2048; i++) begin
         mem[i]   = 16'(i * 40503 + 4660);
         model[i] = 16'(i * 40503 + 4660);
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input logic [23:0] a);
      logic [15:0] w;
      w = model[a[11:1]];
      return a[0] ? w[15:8] : w[7:0];
   endfunction

   task automatic set_ptr(input logic [23:0] a);
      for (int b = 0; b < 3; b++) begin
         ptr_we = 1'b1; ptr_sel = 2'(b); ptr_wdata = a[8*b +: 8];
         @(negedge clk);
      end
      ptr_we = 1'b0;
   endtask

   task automatic tbl_read(input logic [1:0] st);
      tbl_rd = 1'b1; tbl_step = st;
      @(negedge clk);
      tbl_rd = 1'b0; tbl_step = 2'd0;
   endtask

   task automatic tbl_write(input logic [7:0] d, input logic [1:0] st);
      lat_we = 1'b1; lat_wdata = d;
      @(negedge clk);
      lat_we = 1'b0;
      tbl_wr = 1'b1; tbl_step = st;
      @(negedge clk);
      tbl_wr = 1'b0; tbl_step = 2'd0;
   endtask

   task automatic run_cmd(input logic [1:0] op, input string req);
      int n;
      cmd_start = 1'b1; cmd_op = op;
      @(negedge clk);
      cmd_start = 1'b0;
      n = 0;
      while (busy && n < T + 10) begin
         if (!fetch_stall) begin
            n_chk++; n_bad++;
            $display("FAIL R10 (%s): stall low while busy, actual 0 expected 1", req);
         end
         n++;
         @(negedge clk);
      end
      chk({"R10 busy length ", req}, n, T);
      chk({"R10 done pulse ", req}, done, 1);
      @(negedge clk);
      chk({"R10 done clears ", req}, done, 0);
   endtask

   localparam logic [23:0] VA [6] = '{24'h000010, 24'h000011, 24'h0000A3,
                                      24'hFFFFFF, 24'h000000, 24'h012345};
   localparam logic [1:0]  VS [6] = '{2'd1, 2'd0, 2'd2, 2'd1, 2'd2, 2'd3};
   localparam logic [23:0] VN [6] = '{24'h000011, 24'h000011, 24'h0000A2,
                                      24'h000000, 24'hFFFFFF, 24'h012345};

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] w;
      int bad;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ptr", ptr_q, 0);
      chk("R1 latch", lat_q, 0);
      chk("R1 busy", busy, 0);
      chk("R1 stall", fetch_stall, 0);
      chk("R1 err/done", {err, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: staging starts all 0xFF, so a word commit leaves flash unchanged
      set_ptr(24'h000010);
      run_cmd(2'd0, "R1 blank commit");
      chk("R1 staging blank", mem[11'h008], model[11'h008]);

      // R2/R3 vector walk
      for (int i = 0; i < 6; i++) begin
         set_ptr(VA[i]);
         tbl_read(VS[i]);
         chk("R2 read byte", lat_q, exp_byte(VA[i]));
         chk("R3 pointer step", ptr_q, VN[i]);
      end

      // R4: byte write and step in the same cycle
      set_ptr(24'h0000FF);
      tbl_rd = 1'b1; tbl_step = 2'd1;
      ptr_we = 1'b1; ptr_sel = 2'd1; ptr_wdata = 8'h55;
      @(negedge clk);
      tbl_rd = 1'b0; ptr_we = 1'b0; tbl_step = 2'd0;
      chk("R4 merged pointer", ptr_q, 24'h005500);
      chk("R4 read used old pointer", lat_q, exp_byte(24'h0000FF));

      // R5: table writes stage only
      set_ptr(24'h000102);
      tbl_write(8'h3C, 2'd1);
      chk("R5 write step", ptr_q, 24'h000103);
      tbl_write(8'hC3, 2'd0);
      set_ptr(24'h000102);
      tbl_read(2'd0);
      chk("R5 flash untouched", lat_q, exp_byte(24'h000102));

      // R6: word commit
      run_cmd(2'd0, "R6 word");
      model[11'h081] = model[11'h081] & 16'hC33C;
      tbl_read(2'd1);
      chk("R6 low byte", lat_q, exp_byte(24'h000102));
      tbl_read(2'd0);
      chk("R6 high byte", lat_q, exp_byte(24'h000103));

      // R11: staging cleared after commit
      set_ptr(24'h000302);
      run_cmd(2'd0, "R11 recommit");
      chk("R11 staging refilled", mem[11'h181], model[11'h181]);

      // R10: table read and new command ignored while busy
      lat_we = 1'b1; lat_wdata = 8'h77;
      @(negedge clk);
      lat_we = 1'b0;
      cmd_start = 1'b1; cmd_op = 2'd0;
      @(negedge clk);
      cmd_start = 1'b0;
      chk("R10 busy after start", busy, 1);
      tbl_rd = 1'b1; tbl_step = 2'd1; cmd_start = 1'b1; cmd_op = 2'd3;
      @(negedge clk);
      tbl_rd = 1'b0; tbl_step = 2'd0; cmd_start = 1'b0;
      chk("R10 latch held while busy", lat_q, 8'h77);
      chk("R10 pointer held while busy", ptr_q, 24'h000302);
      chk("R10 no err while busy", err, 0);
      while (busy) @(negedge clk);
      @(negedge clk);

      // R8: erase block
      set_ptr(24'h0007AB);
      run_cmd(2'd2, "R8 erase");
      bad = 0;
      for (int k = 11'h200; k < 11'h400; k++) begin
         if (mem[k] !== 16'hFFFF) bad++;
         model[k] = 16'hFFFF;
      end
      chk("R8 block erased", bad, 0);
      chk("R8 below untouched", mem[11'h1FF], model[11'h1FF]);
      chk("R8 above untouched", mem[11'h400], model[11'h400]);

      // R7: block commit
      set_ptr(24'h000440);
      for (int k = 0; k < 64; k++) tbl_write(8'(k) ^ 8'hA5, 2'd1);
      set_ptr(24'h00045F);
      run_cmd(2'd1, "R7 block");
      for (int k = 0; k < 32; k++) begin
         w = {8'(2*k+1) ^ 8'hA5, 8'(2*k) ^ 8'hA5};
         model[11'h220 + k] = model[11'h220 + k] & w;
      end
      set_ptr(24'h00043F);
      for (int k = 0; k < 66; k++) begin
         tbl_read(2'd1);
         chk("R7 block data", lat_q, exp_byte(24'h00043F + 24'(k)));
      end

      // R9: bulk erase refused
      cmd_start = 1'b1; cmd_op = 2'd3;
      @(negedge clk);
      cmd_start = 1'b0;
      chk("R9 err pulse", err, 1);
      chk("R9 not busy", busy, 0);
      @(negedge clk);
      chk("R9 err single cycle", err, 0);
      chk("R9 flash untouched", mem[11'h230], model[11'h230]);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule